// File: doc/BRIEF.md
# Staggered Capture Clock Controller

This block sequences the shift and capture phases of a logic self-test run on a core with several clock domains (two by default). It drives one shared, slow scan-enable line. It also produces per-domain clock-enable signals, which external gating cells use to pass or block each domain's test clock. In the shift window every domain's enable is held high so the scan chains load and unload together. In the capture window the domains are pulsed one at a time, in index order, with quiet gaps of programmable length around and between them.

Two capture styles are supported. In single-capture mode each domain gets one capture pulse. In double-capture mode each domain gets two back-to-back pulses: the first launches transitions and the second captures the responses. One domain's pair always completes before the next domain's pair starts. The shift window is lengthened by the re-timing depth on one side only, because the pipeline stages in front of the core and those behind it fill and drain in the same cycles.

The block takes a pattern count N. It runs N capture windows, each preceded by a shift window, and then one final shift window to unload the last responses. After that it raises a finish flag. The controller has no data stream, so all pins are plain control and status lines.

Top module: `stc_ctrl`

## Requirements
- R1: During reset and in idle after reset, `scan_en`, every `shift_clk_en` bit, every `cap_clk_en` bit and `done` are low.
- R2: A shift window lasts exactly `shift_len + RETIME_DEPTH` cycles. During it `scan_en` and every `shift_clk_en` bit are high and every `cap_clk_en` bit is low.
- R3: With `dbl_mode` = 0, each domain receives exactly one single-cycle capture pulse per capture window, in ascending domain index (bit 0 first). No two `cap_clk_en` bits are ever high together.
- R4: With `dbl_mode` = 1, each domain's `cap_clk_en` bit is high for exactly two consecutive cycles per capture window. Domain d's pair ends before domain d+1's pair begins.
- R5: A gap of `gap_len` cycles, where a value of 0 is treated as 1, separates the end of the shift window from the first pulse. Gaps of the same length separate one domain's pulses from the next domain's pulses, and the last pulse from the next shift window. During every gap all enables and `scan_en` are low.
- R6: `scan_en` is low for the whole capture window, gaps included. It changes only where a shift window meets a gap, never next to a capture pulse.
- R7: A pattern count N yields N capture windows and N+1 shift windows. After the last shift window `done` goes high with all other outputs low, and stays high until the next accepted `start`.
- R8: `start`, `dbl_mode`, `shift_len`, `pattern_cnt` and `gap_len` are sampled only when `start` is accepted in idle or in the finished state. Changes to them during a run have no effect on the outputs.
- R9: When `start` is sampled high in idle or finished state, the first shift cycle appears in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted in idle or finished state) |
| dbl_mode | input | 1 | 0: one capture pulse per domain, 1: launch/capture pulse pair |
| shift_len | input | SHIFT_W | Longest scan chain length in cycles |
| pattern_cnt | input | PAT_W | Number of capture windows in the run |
| gap_len | input | GAP_W | Quiet cycles around and between capture pulses (0 acts as 1) |
| scan_en | output | 1 | Global scan enable, high during shift windows |
| shift_clk_en | output | NUM_DOM | Per-domain clock enable during shift |
| cap_clk_en | output | NUM_DOM | Per-domain capture clock enable, staggered |
| done | output | 1 | Run finished, held until next start |

## Verification
The bench builds the block with NUM_DOM = 2, RETIME_DEPTH = 2, an 8-bit shift length and 4-bit pattern and gap fields. This keeps every run short enough to compare the outputs cycle by cycle against a position-based model of the whole run. It also lets a shift length of 255 reach the full-width case, where the re-timing extension overflows the input field to give a 257-cycle window. The small fields further bring a zero pattern count, a zero gap and a zero shift length within a few cycles, so the edge cases are exercised quickly. The same runs cover restarting from the finished state and driving `start` and the configuration inputs in the middle of a run.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SHIFT    = 3'd1,
    ST_GAP_PRE  = 3'd2,
    ST_PULSE    = 3'd3,
    ST_GAP_MID  = 3'd4,
    ST_GAP_POST = 3'd5,
    ST_DONE     = 3'd6
  } stc_state_e;

  function automatic bit is_gap(stc_state_e s);
    return (s == ST_GAP_PRE) || (s == ST_GAP_MID) || (s == ST_GAP_POST);
  endfunction

endpackage

// File: rtl/stc_phase_timer.sv
module stc_phase_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/stc_pattern_tracker.sv
module stc_pattern_tracker #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         none_left
);

  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (dec && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign none_left = (left_q == '0);

endmodule

// File: rtl/stc_enable_decode.sv
module stc_enable_decode
  import stc_pkg::*;
#(
  parameter int NUM_DOM = 2,
  parameter int DOM_W   = 1
) (
  input  stc_state_e         state,
  input  logic [DOM_W-1:0]   dom,
  output logic               scan_en,
  output logic [NUM_DOM-1:0] shift_clk_en,
  output logic [NUM_DOM-1:0] cap_clk_en,
  output logic               done
);

  logic in_shift;
  logic in_pulse;

  assign in_shift = (state == ST_SHIFT);
  assign in_pulse = (state == ST_PULSE);
  assign scan_en  = in_shift;
  assign done     = (state == ST_DONE);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign shift_clk_en[d] = in_shift;
    assign cap_clk_en[d]   = in_pulse && (dom == DOM_W'(d));
  end

endmodule

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
#(
  parameter int NUM_DOM      = 2,
  parameter int SHIFT_W      = 16,
  parameter int PAT_W        = 16,
  parameter int GAP_W        = 8,
  parameter int RETIME_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dbl_mode,
  input  logic [SHIFT_W-1:0] shift_len,
  input  logic [PAT_W-1:0]   pattern_cnt,
  input  logic [GAP_W-1:0]   gap_len,
  output logic               scan_en,
  output logic [NUM_DOM-1:0] shift_clk_en,
  output logic [NUM_DOM-1:0] cap_clk_en,
  output logic               done
);

  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam int BASE_W = (SHIFT_W > GAP_W) ? SHIFT_W : GAP_W;
  localparam int LEN_W  = BASE_W + $clog2(RETIME_DEPTH + 2) + 1;
  localparam logic [DOM_W-1:0] LAST_DOM = DOM_W'(NUM_DOM - 1);

  stc_state_e state_q, state_d;
  logic [DOM_W-1:0]   dom_q, dom_d;
  logic               dbl_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [GAP_W-1:0]   gap_q;

  logic               accept;
  logic               timer_load;
  logic [LEN_W-1:0]   timer_val;
  logic               timer_done;
  logic               pat_dec;
  logic               pat_none;

  logic [LEN_W-1:0]   shift_m1_live, shift_m1_held;
  logic [LEN_W-1:0]   gap_m1_held;
  logic [LEN_W-1:0]   pulse_m1_held;

  // Window lengths minus one, as loaded into the phase timer.
  function automatic logic [LEN_W-1:0] shift_m1(logic [SHIFT_W-1:0] len);
    logic [LEN_W-1:0] full;
    full = LEN_W'(len) + LEN_W'(RETIME_DEPTH);
    return (full == '0) ? '0 : full - 1'b1;
  endfunction

  function automatic logic [LEN_W-1:0] gap_m1(logic [GAP_W-1:0] len);
    return (len == '0) ? '0 : LEN_W'(len) - 1'b1;
  endfunction

  assign shift_m1_live = shift_m1(shift_len);
  assign shift_m1_held = shift_m1(shift_q);
  assign gap_m1_held   = gap_m1(gap_q);
  assign pulse_m1_held = dbl_q ? LEN_W'(1) : '0;

  assign accept = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  // Configuration is captured only when a run is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbl_q   <= 1'b0;
      shift_q <= '0;
      gap_q   <= '0;
    end else if (accept) begin
      dbl_q   <= dbl_mode;
      shift_q <= shift_len;
      gap_q   <= gap_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dom_q   <= '0;
    end else begin
      state_q <= state_d;
      dom_q   <= dom_d;
    end
  end

  always_comb begin
    state_d    = state_q;
    dom_d      = dom_q;
    timer_load = 1'b0;
    timer_val  = '0;
    pat_dec    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          state_d    = ST_SHIFT;
          timer_load = 1'b1;
          timer_val  = shift_m1_live;
        end
      end
      ST_SHIFT: begin
        if (timer_done) begin
          if (pat_none) begin
            state_d = ST_DONE;
          end else begin
            state_d    = ST_GAP_PRE;
            timer_load = 1'b1;
            timer_val  = gap_m1_held;
          end
        end
      end
      ST_GAP_PRE: begin
        if (timer_done) begin
          state_d    = ST_PULSE;
          dom_d      = '0;
          timer_load = 1'b1;
          timer_val  = pulse_m1_held;
        end
      end
      ST_PULSE: begin
        if (timer_done) begin
          state_d    = (dom_q == LAST_DOM) ? ST_GAP_POST : ST_GAP_MID;
          timer_load = 1'b1;
          timer_val  = gap_m1_held;
        end
      end
      ST_GAP_MID: begin
        if (timer_done) begin
          state_d    = ST_PULSE;
          dom_d      = dom_q + 1'b1;
          timer_load = 1'b1;
          timer_val  = pulse_m1_held;
        end
      end
      ST_GAP_POST: begin
        if (timer_done) begin
          state_d    = ST_SHIFT;
          pat_dec    = 1'b1;
          timer_load = 1'b1;
          timer_val  = shift_m1_held;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  stc_phase_timer #(.W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_done)
  );

  stc_pattern_tracker #(.W(PAT_W)) u_patterns (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_val  (pattern_cnt),
    .dec       (pat_dec),
    .none_left (pat_none)
  );

  stc_enable_decode #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_decode (
    .state        (state_q),
    .dom          (dom_q),
    .scan_en      (scan_en),
    .shift_clk_en (shift_clk_en),
    .cap_clk_en   (cap_clk_en),
    .done         (done)
  );

endmodule

// File: rtl/stc_ctrl_chk.sv
module stc_ctrl_chk #(
  parameter int NUM_DOM = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dbl_q,
  input logic               scan_en,
  input logic [NUM_DOM-1:0] shift_clk_en,
  input logic [NUM_DOM-1:0] cap_clk_en,
  input logic               done
);

  // Domains that have pulsed since the last shift window.
  logic [NUM_DOM-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (scan_en) begin
      seen_q <= '0;
    end else begin
      seen_q <= seen_q | cap_clk_en;
    end
  end

  a_r2_shift_all_domains: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (&shift_clk_en) && (cap_clk_en == '0));

  a_r2_no_shift_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> (shift_clk_en == '0));

  a_r3_one_domain_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_clk_en));

  a_r6_fall_into_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |-> (cap_clk_en == '0));

  a_r6_rise_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_en) |-> ($past(cap_clk_en) == '0));

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scan_en && (shift_clk_en == '0) && (cap_clk_en == '0));

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    a_r4_pair_second: assert property (@(posedge clk) disable iff (!rst_n)
      (dbl_q && $rose(cap_clk_en[d])) |=> cap_clk_en[d]);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbl_q && cap_clk_en[d]) |=> !cap_clk_en[d]);

    a_r5_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cap_clk_en[d]) |-> (cap_clk_en == '0) && !scan_en);

    if (d > 0) begin : g_order
      a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_clk_en[d]) |-> seen_q[d-1]);
    end
  end

endmodule

bind stc_ctrl stc_ctrl_chk #(.NUM_DOM(NUM_DOM)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dbl_q        (dbl_q),
  .scan_en      (scan_en),
  .shift_clk_en (shift_clk_en),
  .cap_clk_en   (cap_clk_en),
  .done         (done)
);

// File: tb/sim_stc_ctrl.sv
module sim_stc_ctrl;

  localparam int ND  = 2;
  localparam int SW  = 8;
  localparam int PW  = 4;
  localparam int GW  = 4;
  localparam int RTD = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          dbl_mode;
  logic [SW-1:0] shift_len;
  logic [PW-1:0] pattern_cnt;
  logic [GW-1:0] gap_len;
  logic          scan_en;
  logic [ND-1:0] shift_clk_en;
  logic [ND-1:0] cap_clk_en;
  logic          done;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stc_ctrl #(.NUM_DOM(ND), .SHIFT_W(SW), .PAT_W(PW), .GAP_W(GW), .RETIME_DEPTH(RTD)) u0 (
    .clk, .rst_n, .start, .dbl_mode, .shift_len, .pattern_cnt, .gap_len,
    .scan_en, .shift_clk_en, .cap_clk_en, .done
  );

  // {poke, dbl, shift_len[7:0], pattern_cnt[3:0], gap_len[3:0]}
  localparam logic [17:0] VECS [0:5] = '{
    {1'b0, 1'b0, 8'd3,   4'd2, 4'd1},
    {1'b0, 1'b1, 8'd3,   4'd2, 4'd2},
    {1'b1, 1'b0, 8'd0,   4'd1, 4'd0},
    {1'b0, 1'b1, 8'd5,   4'd0, 4'd3},
    {1'b1, 1'b1, 8'd1,   4'd3, 4'd1},
    {1'b0, 1'b0, 8'd255, 4'd1, 4'd2}
  };

  // Packed observation: {done, scan_en, shift_clk_en[1:0], cap_clk_en[1:0]}
  function automatic logic [5:0] observed();
    return {done, scan_en, shift_clk_en, cap_clk_en};
  endfunction

  // Expected outputs at cycle t after the accepted start, built from R2..R7.
  function automatic logic [5:0] expect_at(int t, bit dbl, int sl, int np, int gp);
    int len_s  = sl + RTD;
    int g      = (gp == 0) ? 1 : gp;
    int p      = dbl ? 2 : 1;
    int per    = len_s + g * (ND + 1) + ND * p;
    int r;
    if (t >= np * per) begin
      r = t - np * per;
      return (r < len_s) ? 6'b011100 : 6'b100000;
    end
    r = t % per;
    if (r < len_s) return 6'b011100;
    r -= len_s;
    if (r < g) return 6'b000000;
    r -= g;
    for (int d = 0; d < ND; d++) begin
      if (r < p) return 6'(1 << d);
      r -= p;
      if (d < ND - 1) begin
        if (r < g) return 6'b000000;
        r -= g;
      end
    end
    return 6'b000000;
  endfunction

  function automatic string req_of(logic [5:0] e, bit dbl);
    if (e[5])        return "R7";
    if (e[4])        return "R2";
    if (e[1:0] != 0) return dbl ? "R4" : "R3";
    return "R5/R6";
  endfunction

  task automatic compare(string req, logic [5:0] exp_v);
    logic [5:0] act = observed();
    n_checks++;
    if (act !== exp_v) begin
      n_fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp_v);
    end
  endtask

  task automatic run_vec(logic [17:0] v);
    bit poke    = v[17];
    bit dbl     = v[16];
    int sl      = int'(v[15:8]);
    int np      = int'(v[7:4]);
    int gp      = int'(v[3:0]);
    int g       = (gp == 0) ? 1 : gp;
    int per     = sl + RTD + g * (ND + 1) + ND * (dbl ? 2 : 1);
    int total   = np * per + sl + RTD;
    dbl_mode    = dbl;
    shift_len   = v[15:8];
    pattern_cnt = v[7:4];
    gap_len     = v[3:0];
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < total + 3; t++) begin
      logic [5:0] e = expect_at(t, dbl, sl, np, gp);
      string rq = req_of(e, dbl);
      if (t == 0) rq = "R9";
      else if (poke && t > 3) rq = {rq, "+R8"};
      compare(rq, e);
      if (poke && t == 3) begin
        start       = 1'b1;
        dbl_mode    = ~dbl;
        shift_len   = 8'd40;
        pattern_cnt = 4'd9;
        gap_len     = 4'd7;
      end else if (poke && t == 4) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    start       = 1'b0;
    dbl_mode    = 1'b0;
    shift_len   = '0;
    pattern_cnt = '0;
    gap_len     = '0;
    repeat (3) @(negedge clk);
    compare("R1", 6'b000000);          // R1: reset state
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare("R1", 6'b000000);          // R1: idle after reset
    compare("R1", 6'b000000);

    for (int i = 0; i < 6; i++) begin
      run_vec(VECS[i]);
    end

    // R7: done holds while start stays low
    repeat (4) @(negedge clk);
    compare("R7", 6'b100000);

    // R8: config changes without start leave the finished state untouched
    shift_len = 8'd9;
    gap_len   = 4'd5;
    @(negedge clk);
    compare("R8", 6'b100000);

    // R2/R5: zero gap with double capture, restart straight from done
    run_vec({1'b0, 1'b1, 8'd0, 4'd2, 4'd0});

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule